// File: doc/BRIEF.md
# Delayed Transaction Timeout Monitor

This block guards a single pending delayed transaction held by a PCI target. When the target latches a new delayed request, the block begins counting bus clocks. If the original master comes back and completes the transaction before the count runs out, the block returns to idle without any further action. If the count runs out first, the block issues a one-cycle discard pulse. The target uses that pulse to drop the stored request. The same clock edge also raises a sticky error bit that software can read.

Two timeout lengths are available. The long one is used in normal operation. The short one lets the timeout path be exercised during simulation or bring-up. The length is chosen by a test-mode input that is sampled only when a transaction is latched. The error bit follows register rules: a write with data one clears it, and a write with data zero leaves it unchanged.

Top module: `dly_txn_timeout`

## Requirements
- R1: With `test_mode_i` low when the transaction is latched, `discard_o` is high in the cycle after the NORM_LIMIT-th rising edge that follows the edge sampling `txn_start_i` (default 32768).
- R2: With `test_mode_i` high when the transaction is latched, `discard_o` is high in the cycle after the TEST_LIMIT-th rising edge that follows the start edge (default 160).
- R3: `test_mode_i` is sampled only on the start edge. Changing it while a count runs does not move the timeout.
- R4: `discard_o` is a single-cycle pulse, and `err_o` becomes 1 on the same edge that raises it.
- R5: A write to the error bit (`err_wr_i`=1) with `err_wdata_i`=0 leaves `err_o` unchanged.
- R6: A write with `err_wdata_i`=1 clears `err_o` on the next edge.
- R7: If a timeout and a clearing write fall on the same edge, `err_o` stays 1.
- R8: `txn_done_i` while a transaction is pending returns the block to idle with no discard, including when it arrives on the edge where the count would expire. `txn_done_i` while idle has no effect.
- R9: `txn_start_i` while a transaction is pending restarts the count from zero and samples `test_mode_i` again.
- R10: After reset, `discard_o` and `err_o` are 0 and no count is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txn_start_i | input | 1 | Pulse: a delayed transaction was latched |
| txn_done_i | input | 1 | Pulse: the master returned and completed the transaction |
| test_mode_i | input | 1 | Selects the short timeout, sampled at start |
| err_wr_i | input | 1 | Write strobe for the error bit |
| err_wdata_i | input | 1 | Write data for the error bit (1 clears) |
| discard_o | output | 1 | One-cycle pulse: drop the pending transaction |
| err_o | output | 1 | Sticky timeout error bit |

## Verification
Two pairs of functions can land on the same edge. In the first pair, a timeout coincides with a clearing write to the error bit. In the second, a timeout coincides with the completion of the transaction. The bench provokes each case by taking the cycle number of the start pulse, computing the expiry edge from it, and driving the clearing write or the completion pulse in the cycle just before that edge. In the first case, the scoreboard must see the discard pulse in its predicted cycle and `err_o` must still read 1 afterwards. In the second case, no discard may appear and `err_o` must stay 0.

// File: rtl/dtto_pkg.sv
package dtto_pkg;
  typedef enum logic {DT_IDLE = 1'b0, DT_RUN = 1'b1} dt_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dtto_limit_sel.sv
module dtto_limit_sel #(
  parameter int unsigned NORM_LIMIT = 32768,
  parameter int unsigned TEST_LIMIT = 160,
  parameter int unsigned CNT_W      = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             test_mode_i,
  output logic [CNT_W-1:0] last_o
);
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_LIMIT - 1);
  localparam logic [CNT_W-1:0] TEST_LAST = CNT_W'(TEST_LIMIT - 1);

  logic mode_q;

  // mode frozen per transaction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= 1'b0;
    else if (start_i) mode_q <= test_mode_i;
  end

  assign last_o = mode_q ? TEST_LAST : NORM_LAST;
endmodule

// File: rtl/dtto_counter.sv
module dtto_counter
  import dtto_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             expire_o
);
  dt_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q == last_i);
  // start and done both outrank expiry
  assign expire_o = (state_q == DT_RUN) && !start_i && !done_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DT_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= DT_RUN;
      cnt_q   <= '0;
    end else if (state_q == DT_RUN) begin
      if (done_i || at_last) begin
        state_q <= DT_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtto_err_flag.sv
module dtto_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic err_o
);
  logic err_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= set_i | (err_q & ~(wr_i & wdata_i));
  end

  assign err_o = err_q;
endmodule

// File: rtl/dly_txn_timeout.sv
module dly_txn_timeout
  import dtto_pkg::*;
#(
  parameter int unsigned NORM_LIMIT = 32768,
  parameter int unsigned TEST_LIMIT = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txn_start_i,
  input  logic txn_done_i,
  input  logic test_mode_i,
  input  logic err_wr_i,
  input  logic err_wdata_i,
  output logic discard_o,
  output logic err_o
);
  localparam int unsigned MAX_LIMIT = max_u(NORM_LIMIT, TEST_LIMIT);
  localparam int unsigned CNT_W     = (MAX_LIMIT > 2) ? $clog2(MAX_LIMIT) : 1;

  logic [CNT_W-1:0] last;
  logic             expire;
  logic             discard_q;

  dtto_limit_sel #(
    .NORM_LIMIT(NORM_LIMIT),
    .TEST_LIMIT(TEST_LIMIT),
    .CNT_W     (CNT_W)
  ) u_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (txn_start_i),
    .test_mode_i(test_mode_i),
    .last_o     (last)
  );

  dtto_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (txn_start_i),
    .done_i  (txn_done_i),
    .last_i  (last),
    .expire_o(expire)
  );

  dtto_err_flag u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .wr_i   (err_wr_i),
    .wdata_i(err_wdata_i),
    .err_o  (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) discard_q <= 1'b0;
    else         discard_q <= expire;
  end

  assign discard_o = discard_q;
endmodule

// File: rtl/dly_txn_timeout_chk.sv
module dly_txn_timeout_chk #(
  parameter int unsigned NORM_LIMIT = 32768,
  parameter int unsigned TEST_LIMIT = 160
) (
  input logic clk_i,
  input logic rst_ni,
  input logic txn_start_i,
  input logic txn_done_i,
  input logic test_mode_i,
  input logic err_wr_i,
  input logic err_wdata_i,
  input logic discard_o,
  input logic err_o
);
  // independent window tracker
  logic        run_q;
  logic        mode_q;
  int unsigned cnt_q;
  logic        exp_q;
  int unsigned lim;

  assign lim = mode_q ? TEST_LIMIT : NORM_LIMIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= 0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (txn_start_i) begin
        run_q  <= 1'b1;
        mode_q <= test_mode_i;
        cnt_q  <= 1;
      end else if (run_q) begin
        if (txn_done_i) begin
          run_q <= 1'b0;
        end else if (cnt_q >= lim) begin
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1;
        end
      end
    end
  end

  // R1 R2 R3 R9
  timeout_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o == exp_q);

  // R4
  discard_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |=> !discard_o);

  // R4
  discard_sets_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> err_o);

  // R4
  err_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> discard_o);

  // R5
  w0_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(err_wr_i && err_wdata_i)) |=> err_o);

  // R6 R7
  w1_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_wr_i && err_wdata_i) |=> (err_o == discard_o));

  // R8
  done_no_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_done_i && !txn_start_i) |=> !discard_o);
endmodule

bind dly_txn_timeout dly_txn_timeout_chk #(
  .NORM_LIMIT(NORM_LIMIT),
  .TEST_LIMIT(TEST_LIMIT)
) u_chk (.*);

// File: tb/dly_txn_timeout_tb.sv
`timescale 1ns/1ps
module dly_txn_timeout_tb;
  localparam int NORM = 32768;
  localparam int TEST = 160;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic txn_start_i = 1'b0;
  logic txn_done_i = 1'b0;
  logic test_mode_i = 1'b0;
  logic err_wr_i = 1'b0;
  logic err_wdata_i = 1'b0;
  logic discard_o;
  logic err_o;

  int tests = 0;
  int fails = 0;
  int neg_cnt = 0;
  int exp_q[$];
  bit done_flag = 1'b0;

  always #5 clk_i = ~clk_i;

  dly_txn_timeout #(.NORM_LIMIT(NORM), .TEST_LIMIT(TEST)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .txn_start_i(txn_start_i),
    .txn_done_i(txn_done_i), .test_mode_i(test_mode_i),
    .err_wr_i(err_wr_i), .err_wdata_i(err_wdata_i),
    .discard_o(discard_o), .err_o(err_o));

  task automatic check(string req, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: pops expected discard cycles
  always @(negedge clk_i) begin
    neg_cnt++;
    if (rst_ni && discard_o) begin
      if (exp_q.size() == 0) check("R4/R8 unexpected discard", neg_cnt, -1);
      else check("R1/R2 discard cycle", neg_cnt, exp_q.pop_front());
    end
  end

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wait_until(int n);
    while (neg_cnt < n) step();
  endtask

  // driver: start pulse, optionally pushes expected discard cycle
  task automatic do_start(bit mode, bit expect_to, output int k);
    k = neg_cnt;
    txn_start_i = 1'b1;
    test_mode_i = mode;
    if (expect_to) exp_q.push_back(k + 1 + (mode ? TEST : NORM));
    step();
    txn_start_i = 1'b0;
  endtask

  task automatic do_write(bit d);
    err_wr_i = 1'b1;
    err_wdata_i = d;
    step();
    err_wr_i = 1'b0;
    err_wdata_i = 1'b0;
  endtask

  task automatic do_done();
    txn_done_i = 1'b1;
    step();
    txn_done_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    int k2;
    step();
    step();
    // R10
    check("R10 discard after reset", discard_o, 0);
    check("R10 err after reset", err_o, 0);
    rst_ni = 1'b1;
    step();

    // R2 test-mode timeout, R3 mode dropped mid-count
    do_start(1'b1, 1'b1, k);
    test_mode_i = 1'b0;
    wait_until(k + TEST + 3);
    check("R4 err set by timeout", err_o, 1);
    check("R3 queue drained after test timeout", exp_q.size(), 0);

    // R5 write zero
    do_write(1'b0);
    check("R5 write zero keeps err", err_o, 1);
    // R6 write one
    do_write(1'b1);
    check("R6 write one clears err", err_o, 0);

    // R8 done while idle
    do_done();
    step();
    check("R8 done idle err", err_o, 0);

    // R8 completion before expiry
    do_start(1'b1, 1'b0, k);
    wait_until(k + 100);
    do_done();
    wait_until(k + TEST + 10);
    check("R8 early completion no err", err_o, 0);

    // R8 completion on the expiry edge wins
    do_start(1'b1, 1'b0, k);
    wait_until(k + TEST);
    do_done();
    wait_until(k + TEST + 5);
    check("R8 done at expiry no err", err_o, 0);

    // R7 timeout and clear on the same edge
    do_start(1'b1, 1'b1, k);
    wait_until(k + TEST);
    do_write(1'b1);
    check("R7 set wins over clear", err_o, 1);
    step();
    check("R4 discard single cycle", discard_o, 0);
    check("R7 queue drained", exp_q.size(), 0);
    do_write(1'b1);
    check("R6 cleared after collision", err_o, 0);

    // R9 restart resamples mode
    do_start(1'b0, 1'b0, k);
    wait_until(k + 50);
    do_start(1'b1, 1'b1, k2);
    wait_until(k2 + TEST + 3);
    check("R9 restart timeout err", err_o, 1);
    check("R9 queue drained", exp_q.size(), 0);
    do_write(1'b1);

    // R1 normal timeout, R3 mode raised mid-count
    do_start(1'b0, 1'b1, k);
    wait_until(k + 1000);
    test_mode_i = 1'b1;
    wait_until(k + TEST + 10);
    check("R3 no short timeout after mode change", err_o, 0);
    wait_until(k + NORM);
    check("R1 no err before normal limit", err_o, 0);
    wait_until(k + NORM + 3);
    check("R1 err after normal timeout", err_o, 1);
    check("R1 queue drained", exp_q.size(), 0);

    wait_until(neg_cnt + 5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule